// File: doc/BRIEF.md
# Four-Output Pulse-Width Modulator Group with Edge/Center Alignment

This block drives four pulse-width modulated outputs from one shared period counter. The counter either ramps up and wraps, which gives edge-aligned pulses, or ramps up to the period value and back down, which gives pulses centred on the top of the ramp. The four outputs form two pairs. In paired operation each pair produces a signal and its exact complement from one duty value. In independent operation each output has its own duty value.

Software-side writes land in shadow registers: one for the period and four duty slots. The alignment and pairing selection pins are sampled the same way. All of these reach the active copies only when the counter starts a new period, so a waveform never changes shape partway through a period. A one-cycle `cyc_start` pulse marks the first cycle of each period.

The timebase is a two-state machine. `ST_RISE` counts up. Its transitions are `RISE->RISE` on an ordinary increment and on the edge-mode wrap (count at period−1, next count 0, reload), and `RISE->FALL` in center mode when the count reaches period−1 (the next count is the period value). `ST_FALL` counts down. Its transitions are `FALL->FALL` on a decrement and `FALL->RISE` when the count is 1 (the next count is 0, reload).

Top module: `pwm_quad_group`

## Requirements
- R1: Reset behaviour. While reset is asserted and in the first cycle after it is released, the count is 0, all four outputs are low and `cyc_start` is high. Reset sets the shadow and active period to parameter `DEF_PERIOD`, sets all duties to 0, and selects edge alignment with independent outputs.
- R2: Edge alignment (`cfg_center`=0 latched). Within a period of active value P, the count takes the values 0..P−1, so the period lasts P cycles. An output with duty d is high exactly while count < d.
- R3: Center alignment (`cfg_center`=1 latched). The count takes the values 0,1..P and then P−1 down to 1, so the period lasts 2P cycles. An output with duty d (0<d<P) is high exactly while P − count < d.
- R4: Paired operation (`cfg_paired`=1 latched). `pwm_out[0]` uses duty slot 0 and `pwm_out[1]` is its complement. `pwm_out[2]` uses duty slot 2 and `pwm_out[3]` is its complement. Slots 1 and 3 have no effect.
- R5: Independent operation (`cfg_paired`=0 latched). `pwm_out[i]` uses duty slot i for each i in 0..3.
- R6: A duty of 0 holds its output low for the whole period. A duty ≥ P holds it high for the whole period. In paired operation the complement output shows the inverse.
- R7: `per_we` stores `per_data` in the shadow period. `duty_we[i]` stores `duty_data` in shadow slot i. The shadow values, together with `cfg_center` and `cfg_paired`, are copied to the active set only at the clock edge that starts a new period. A period already running keeps its old values to its end.
- R8: `cyc_start` is high exactly in the first cycle of each period (count 0) and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_center | input | 1 | 1 = center alignment, 0 = edge alignment; sampled at period start |
| cfg_paired | input | 1 | 1 = complementary pairs, 0 = four independent outputs; sampled at period start |
| per_we | input | 1 | Write strobe for the shadow period |
| per_data | input | CW | Period value to store |
| duty_we | input | 4 | Per-slot write strobes for the shadow duties |
| duty_data | input | CW | Duty value stored in every slot whose strobe is set |
| pwm_out | output | 4 | Modulated outputs |
| cyc_start | output | 1 | High in the first cycle of each period |

## Verification
The assertions take for granted that every active period is at least 2. With that limit, `cyc_start` can never be high in two consecutive cycles, and the count stays within 0..P. They also assume duty values are compared only against the period that is active at the time. The stimulus only writes periods between 2 and 8. It changes the mode pins and shadow values only between checked periods, except in the dedicated mid-period write test. Before checking a new setting, it waits for one period boundary that comes strictly after its last write.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;
    localparam int NOUT = 4;

    typedef enum logic [0:0] {
        ST_RISE = 1'b0,
        ST_FALL = 1'b1
    } ramp_state_t;
endpackage

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
    import pwm_grp_pkg::*;
#(
    parameter int CW         = 8,
    parameter int DEF_PERIOD = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reload,
    input  logic                      cfg_center,
    input  logic                      cfg_paired,
    input  logic                      per_we,
    input  logic [CW-1:0]             per_data,
    input  logic [NOUT-1:0]           duty_we,
    input  logic [CW-1:0]             duty_data,
    output logic [CW-1:0]             act_period,
    output logic [NOUT-1:0][CW-1:0]   act_duty,
    output logic                      act_center,
    output logic                      act_paired
);
    localparam logic [CW-1:0] PER_RST = CW'(DEF_PERIOD);

    logic [CW-1:0] sh_period;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_period  <= PER_RST;
            act_period <= PER_RST;
            act_center <= 1'b0;
            act_paired <= 1'b0;
        end else begin
            if (per_we) sh_period <= per_data;
            if (reload) begin
                act_period <= sh_period;
                act_center <= cfg_center;
                act_paired <= cfg_paired;
            end
        end
    end

    for (genvar gi = 0; gi < NOUT; gi++) begin : g_slot
        logic [CW-1:0] sh_duty;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_duty      <= '0;
                act_duty[gi] <= '0;
            end else begin
                if (duty_we[gi]) sh_duty <= duty_data;
                if (reload) act_duty[gi] <= sh_duty;
            end
        end
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_grp_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] act_period,
    input  logic          act_center,
    output logic [CW-1:0] cnt,
    output logic          reload,
    output logic          cyc_start
);
    localparam logic [CW-1:0] ONE = CW'(1);

    ramp_state_t state, state_nx;
    logic [CW-1:0] cnt_nx;

    // next-state and count logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        reload   = 1'b0;
        unique case (state)
            ST_RISE: begin
                if (cnt >= act_period - ONE) begin
                    if (act_center) begin
                        state_nx = ST_FALL;
                        cnt_nx   = act_period;
                    end else begin
                        cnt_nx = '0;
                        reload = 1'b1;
                    end
                end else begin
                    cnt_nx = cnt + ONE;
                end
            end
            ST_FALL: begin
                if (cnt <= ONE) begin
                    state_nx = ST_RISE;
                    cnt_nx   = '0;
                    reload   = 1'b1;
                end else begin
                    cnt_nx = cnt - ONE;
                end
            end
            default: begin
                state_nx = ST_RISE;
                cnt_nx   = '0;
                reload   = 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RISE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        cyc_start = (cnt == '0);
    end
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
    import pwm_grp_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic [CW-1:0]           cnt,
    input  logic [CW-1:0]           act_period,
    input  logic [NOUT-1:0][CW-1:0] act_duty,
    input  logic                    act_center,
    input  logic                    act_paired,
    output logic [NOUT-1:0]         pwm_out
);
    for (genvar gi = 0; gi < NOUT; gi++) begin : g_cmp
        localparam int PAIR_BASE = gi & ~1;
        localparam bit IS_ODD    = (gi % 2) == 1;
        logic [CW-1:0] duty_sel;
        logic          level;

        always_comb begin
            duty_sel = act_paired ? act_duty[PAIR_BASE] : act_duty[gi];
            if (duty_sel == '0)
                level = 1'b0;
            else if (duty_sel >= act_period)
                level = 1'b1;
            else if (act_center)
                level = ((act_period - cnt) < duty_sel);
            else
                level = (cnt < duty_sel);
            pwm_out[gi] = (act_paired && IS_ODD) ? ~level : level;
        end
    end
endmodule

// File: rtl/pwm_quad_group.sv
module pwm_quad_group
    import pwm_grp_pkg::*;
#(
    parameter int CW         = 8,
    parameter int DEF_PERIOD = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_center,
    input  logic          cfg_paired,
    input  logic          per_we,
    input  logic [CW-1:0] per_data,
    input  logic [3:0]    duty_we,
    input  logic [CW-1:0] duty_data,
    output logic [3:0]    pwm_out,
    output logic          cyc_start
);
    logic [CW-1:0]           cnt;
    logic                    reload;
    logic [CW-1:0]           act_period;
    logic [NOUT-1:0][CW-1:0] act_duty;
    logic                    act_center;
    logic                    act_paired;

    pwm_shadow_bank #(.CW(CW), .DEF_PERIOD(DEF_PERIOD)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (reload),
        .cfg_center (cfg_center),
        .cfg_paired (cfg_paired),
        .per_we     (per_we),
        .per_data   (per_data),
        .duty_we    (duty_we),
        .duty_data  (duty_data),
        .act_period (act_period),
        .act_duty   (act_duty),
        .act_center (act_center),
        .act_paired (act_paired)
    );

    pwm_timebase #(.CW(CW)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_period (act_period),
        .act_center (act_center),
        .cnt        (cnt),
        .reload     (reload),
        .cyc_start  (cyc_start)
    );

    pwm_compare #(.CW(CW)) u_cmp (
        .cnt        (cnt),
        .act_period (act_period),
        .act_duty   (act_duty),
        .act_center (act_center),
        .act_paired (act_paired),
        .pwm_out    (pwm_out)
    );
endmodule

// File: rtl/pwm_quad_group_chk.sv
module pwm_quad_group_chk #(
    parameter int CW = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CW-1:0]        cnt,
    input logic [CW-1:0]        act_period,
    input logic                 act_center,
    input logic                 act_paired,
    input logic [3:0][CW-1:0]   act_duty,
    input logic [3:0]           pwm_out,
    input logic                 cyc_start
);
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !cyc_start);                                       // R8

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_period);                                              // R3

    AST_EDGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_center && cnt == act_period - CW'(1)) |=> cyc_start);      // R2

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |-> ($stable(act_period) && $stable(act_duty)
                        && $stable(act_center) && $stable(act_paired))); // R7

    AST_PAIR0_COMP: assert property (@(posedge clk) disable iff (!rst_n)
        act_paired |-> (pwm_out[1] != pwm_out[0]));                      // R4

    AST_PAIR1_COMP: assert property (@(posedge clk) disable iff (!rst_n)
        act_paired |-> (pwm_out[3] != pwm_out[2]));                      // R4

    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_paired && act_duty[2] == '0) |-> !pwm_out[2]);             // R6

    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_paired && act_duty[1] >= act_period) |-> pwm_out[1]);      // R6
endmodule

bind pwm_quad_group pwm_quad_group_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (cnt),
    .act_period (act_period),
    .act_center (act_center),
    .act_paired (act_paired),
    .act_duty   (act_duty),
    .pwm_out    (pwm_out),
    .cyc_start  (cyc_start)
);

// File: tb/sim_pwm_quad_group.sv
module sim_pwm_quad_group;
    localparam int CW = 8;
    localparam int DEFP = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_center = 1'b0;
    logic          cfg_paired = 1'b0;
    logic          per_we = 1'b0;
    logic [CW-1:0] per_data = '0;
    logic [3:0]    duty_we = '0;
    logic [CW-1:0] duty_data = '0;
    logic [3:0]    pwm_out;
    logic          cyc_start;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // injection for the mid-period write test (R7)
    bit            inj_en = 0;
    int            inj_per = 0;
    int            inj_duty = 0;

    always #4 clk = ~clk;   // 125 MHz

    pwm_quad_group #(.CW(CW), .DEF_PERIOD(DEFP)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_center(cfg_center), .cfg_paired(cfg_paired),
        .per_we(per_we), .per_data(per_data), .duty_we(duty_we), .duty_data(duty_data),
        .pwm_out(pwm_out), .cyc_start(cyc_start)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic bit lvl(int c, int p, int d, bit ctr);
        if (d == 0) return 1'b0;
        if (d >= p) return 1'b1;
        if (ctr) return (p - c) < d;
        return c < d;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(int p, bit ctr, bit pr, int d0, int d1, int d2, int d3);
        int dv[4];
        dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
        @(negedge clk);
        cfg_center = ctr;
        cfg_paired = pr;
        per_we = 1'b1;
        per_data = CW'(p);
        @(negedge clk);
        per_we = 1'b0;
        for (int i = 0; i < 4; i++) begin
            duty_we = 4'(1 << i);
            duty_data = CW'(dv[i]);
            @(negedge clk);
        end
        duty_we = '0;
        @(negedge clk);
        if (cyc_start) @(negedge clk);
        while (!cyc_start) @(negedge clk);
    endtask

    // checks one full period starting at a negedge where cyc_start is high
    task automatic run_period(string req, int p, bit ctr, bit pr,
                              int d0, int d1, int d2, int d3);
        int len;
        int c;
        logic [3:0] e;
        len = ctr ? 2 * p : p;
        for (int k = 0; k < len; k++) begin
            c = (ctr && k > p) ? 2 * p - k : k;
            if (pr) begin
                e[0] = lvl(c, p, d0, ctr);
                e[1] = ~e[0];
                e[2] = lvl(c, p, d2, ctr);
                e[3] = ~e[2];
            end else begin
                e[0] = lvl(c, p, d0, ctr);
                e[1] = lvl(c, p, d1, ctr);
                e[2] = lvl(c, p, d2, ctr);
                e[3] = lvl(c, p, d3, ctr);
            end
            chk(req, int'(pwm_out), int'(e));
            chk("R8 cyc_start", int'(cyc_start), (k == 0) ? 1 : 0);
            if (inj_en && k == 1) begin
                per_we = 1'b1;
                per_data = CW'(inj_per);
                duty_we = 4'hf;
                duty_data = CW'(inj_duty);
            end else if (inj_en && k == 2) begin
                per_we = 1'b0;
                duty_we = 4'h0;
            end
            @(negedge clk);
        end
        chk("R8 next period start", int'(cyc_start), 1);
    endtask

    initial begin
        int plist[4];
        int dd[4];
        plist[0] = 2; plist[1] = 3; plist[2] = 5; plist[3] = 8;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", int'(pwm_out), 0);
        chk("R1 cyc_start in reset", int'(cyc_start), 1);
        rst_n = 1'b1;
        chk("R1 first cycle after reset", int'(cyc_start), 1);
        run_period("R1 default period, zero duty", DEFP, 1'b0, 1'b0, 0, 0, 0, 0);

        // R2 R3 R4 R5 R6: sweep over periods, modes and duty sets
        for (int pi = 0; pi < 4; pi++) begin
            for (int m = 0; m < 4; m++) begin
                for (int s = 0; s < 2; s++) begin
                    int p;
                    bit ctr;
                    bit pr;
                    p = plist[pi];
                    ctr = m[0];
                    pr = m[1];
                    if (s == 0) begin
                        dd[0] = 1; dd[1] = p / 2; dd[2] = p - 1; dd[3] = 0;
                    end else begin
                        dd[0] = 0; dd[1] = p + 2; dd[2] = p; dd[3] = (p + 1) / 2;
                    end
                    set_cfg(p, ctr, pr, dd[0], dd[1], dd[2], dd[3]);
                    if (pr)
                        run_period(ctr ? "R3 R4 R6 center paired" : "R2 R4 R6 edge paired",
                                   p, ctr, pr, dd[0], dd[1], dd[2], dd[3]);
                    else
                        run_period(ctr ? "R3 R5 R6 center independent" : "R2 R5 R6 edge independent",
                                   p, ctr, pr, dd[0], dd[1], dd[2], dd[3]);
                end
            end
        end

        // R7: writes and mode change mid-period do not affect the running period
        set_cfg(5, 1'b0, 1'b0, 2, 2, 2, 2);
        inj_en = 1; inj_per = 7; inj_duty = 4;
        cfg_center = 1'b1;
        cfg_paired = 1'b1;
        run_period("R7 running period keeps old values", 5, 1'b0, 1'b0, 2, 2, 2, 2);
        inj_en = 0;
        run_period("R7 new values from next period", 7, 1'b1, 1'b1, 4, 4, 4, 4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule